// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block is a bus master that turns single-byte read and write requests from a core into cycles on an external 8-bit multiplexed address/data bus. Each cycle starts with an address phase: a latch strobe is high, the low address byte is on the shared lines and the high address byte is on a separate set of lines. A data phase follows with an active-low read or write strobe. The core sees a request/ready handshake. Read data comes back with a one-clock response pulse.

The 16-bit address space is split into a lower and an upper sector at a programmable boundary aligned to 8 KB. Each sector has its own 2-bit wait code. A high-address mask releases upper address pins back to their ordinary port values. An enable flag hands the pins to the controller. A bus keeper, which does not depend on that flag, holds the last driven byte on the shared lines while they float.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `rd_n_o` and `wr_n_o` are high, `ale_o` and `rsp_valid` are low, `req_ready` is high, and with the port inputs at zero `ad_oe` and `keep_o` are low.
- R2: An accepted request whose address is below 0x1100, or any request while `cfg_en` is 0, starts no external cycle: `ale_o` stays low, no strobe falls, no response pulse appears, and `req_ready` stays high. Address 0x1100 does start a cycle.
- R3: In the clock after a request is accepted, `ale_o` is high, `ad_o` carries address bits 7:0 with `ad_oe` high, and the driven high-address pins carry address bits 15:8. The read or write strobe goes low in the next clock.
- R4: The strobe stays low for 1, 2, 3 or 3 clocks for wait codes 00, 01, 10 and 11.
- R5: After the strobe there is one tail clock before `req_ready` returns high. Wait code 11 adds one further idle clock.
- R6: With `cfg_limit` = 0 every external access uses `cfg_wait_hi`. With `cfg_limit` = L nonzero, an address whose bits 15:13 are below L uses `cfg_wait_lo`, and any other address uses `cfg_wait_hi`.
- R7: During every clock of a write strobe, `ad_oe` is high and `ad_o` equals the write byte.
- R8: During a read strobe `ad_oe` is low. `ad_i` is sampled on the last strobe clock, and in the following clock `rsp_valid` is high for exactly one clock with that byte on `rsp_rdata`.
- R9: With `cfg_en` set and `cfg_hmask` = k, the controller drives the high-address bits 0 up to 7−k (k = 0 gives all 8 bits, k = 7 gives none) with `hi_oe` high. The remaining bits take `port_hi_out` and `port_hi_oe`.
- R10: With `cfg_en` clear, `ad_o`/`ad_oe` follow `port_ad_out`/`port_ad_oe`, `hi_o`/`hi_oe` follow `port_hi_out`/`port_hi_oe`, and both strobes and `ale_o` stay inactive.
- R11: When `ad_oe` is low, `keep_o` equals `cfg_keep`. `ad_o` then shows the last driven byte if `cfg_keep` is set and 0x00 otherwise. This holds whatever the value of `cfg_en`.
- R12: In the tail clock, `ale_o` is high exactly when `req_valid` is high.
- R13: `req_ready` is low from the address clock until the cycle ends. A request held across that time is accepted once ready returns, and its address phase follows in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Hand bus pins to the controller |
| cfg_limit | input | 3 | Sector boundary in 8 KB units; 0 means a single upper sector |
| cfg_wait_lo | input | 2 | Wait code for the lower sector |
| cfg_wait_hi | input | 2 | Wait code for the upper sector |
| cfg_hmask | input | 3 | High-address mask code |
| cfg_keep | input | 1 | Bus keeper enable |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| rsp_valid | output | 1 | One-clock read data pulse |
| rsp_rdata | output | 8 | Read byte |
| port_ad_out | input | 8 | Ordinary port value for the shared lines |
| port_ad_oe | input | 1 | Ordinary port direction for the shared lines |
| port_hi_out | input | 8 | Ordinary port value for the high lines |
| port_hi_oe | input | 8 | Ordinary port direction for the high lines |
| ad_i | input | 8 | Shared lines as seen at the pins |
| ad_o | output | 8 | Shared line output value |
| ad_oe | output | 1 | Shared line output enable |
| hi_o | output | 8 | High-address line values |
| hi_oe | output | 8 | High-address line enables |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| keep_o | output | 1 | Bus keeper active on the shared lines |

## Verification
The tail clock of one cycle can also carry the address latch strobe that announces the next access. A second request therefore has to be raised during the strobe of the first. The bench does this and checks three things: ready stays low while the request waits, the latch strobe appears in the tail clock, and the held request gets its address phase right after ready returns. The read sample and the response pulse also fall next to the strobe release. The bench changes `ad_i` on every strobe clock, so only a sample taken on the last strobe clock matches the expected byte.

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
  parameter logic [15:0] EXT_BASE = 16'h1100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_en,
  input  logic [2:0]  cfg_limit,
  input  logic [1:0]  cfg_wait_lo,
  input  logic [1:0]  cfg_wait_hi,
  input  logic [2:0]  cfg_hmask,
  input  logic        cfg_keep,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  input  logic [7:0]  port_ad_out,
  input  logic        port_ad_oe,
  input  logic [7:0]  port_hi_out,
  input  logic [7:0]  port_hi_oe,
  input  logic [7:0]  ad_i,
  output logic [7:0]  ad_o,
  output logic        ad_oe,
  output logic [7:0]  hi_o,
  output logic [7:0]  hi_oe,
  output logic        ale_o,
  output logic        rd_n_o,
  output logic        wr_n_o,
  output logic        keep_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_STRB, S_TAIL, S_GAP} st_t;

  st_t         st;
  logic [15:0] a_q;
  logic [7:0]  d_q, rdata_q, last_ad;
  logic        wr_q, rsp_q;
  logic [1:0]  wt_q, cnt;

  wire ext_hit  = req_addr >= EXT_BASE;
  wire in_lower = (cfg_limit != 3'd0) && (req_addr[15:13] < cfg_limit);
  wire [1:0] sel_wait = in_lower ? cfg_wait_lo : cfg_wait_hi;
  wire [1:0] strb_lim = (wt_q == 2'd0) ? 2'd0 : (wt_q == 2'd1) ? 2'd1 : 2'd2;
  wire strb_last = cnt == strb_lim;
  wire accept = req_valid && req_ready;

  assign req_ready = st == S_IDLE;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      a_q     <= '0;
      d_q     <= '0;
      wr_q    <= 1'b0;
      wt_q    <= '0;
      cnt     <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (st)
        S_IDLE: if (accept && cfg_en && ext_hit) begin
          st   <= S_ADDR;
          a_q  <= req_addr;
          d_q  <= req_wdata;
          wr_q <= req_write;
          wt_q <= sel_wait;
        end
        S_ADDR: begin
          st  <= S_STRB;
          cnt <= '0;
        end
        S_STRB: if (strb_last) begin
          st <= S_TAIL;
          if (!wr_q) begin
            rdata_q <= ad_i;
            rsp_q   <= 1'b1;
          end
        end else begin
          cnt <= cnt + 2'd1;
        end
        S_TAIL: st <= (wt_q == 2'd3) ? S_GAP : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire       ctl_oe = (st == S_ADDR) || (st == S_STRB && wr_q);
  wire [7:0] ctl_ad = (st == S_ADDR) ? a_q[7:0] : d_q;
  wire [7:0] drv_ad = cfg_en ? ctl_ad : port_ad_out;

  assign ad_oe  = cfg_en ? ctl_oe : port_ad_oe;
  assign ad_o   = ad_oe ? drv_ad : (cfg_keep ? last_ad : 8'h00);
  assign keep_o = cfg_keep && !ad_oe;
  assign ale_o  = cfg_en && ((st == S_ADDR) || (st == S_TAIL && req_valid));
  assign rd_n_o = !(cfg_en && st == S_STRB && !wr_q);
  assign wr_n_o = !(cfg_en && st == S_STRB && wr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_ad <= '0;
    else if (ad_oe) last_ad <= drv_ad;
  end

  wire [3:0] hi_cnt = (cfg_hmask == 3'd7) ? 4'd0 : 4'd8 - {1'b0, cfg_hmask};

  for (genvar i = 0; i < 8; i++) begin : g_hi
    wire own = cfg_en && (i < hi_cnt);
    assign hi_o[i]  = own ? a_q[8+i] : port_hi_out[i];
    assign hi_oe[i] = own ? 1'b1 : port_hi_oe[i];
  end

  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rsp_after_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!rd_n_o));
  p_rd_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe);
  p_wr_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> ad_oe);
  p_strb_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));
  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (rd_n_o && wr_n_o && !ale_o));
  p_keep_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_keep && $past(cfg_keep) && !ad_oe && $past(ad_oe)) |-> ad_o == $past(ad_o));
  p_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> !req_ready);

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_keep = 0;
  logic [2:0] cfg_limit = 0, cfg_hmask = 0;
  logic [1:0] cfg_wait_lo = 0, cfg_wait_hi = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [7:0] rsp_rdata;
  logic [7:0] port_ad_out = 0, port_hi_out = 0, port_hi_oe = 0, ad_i = 0;
  logic port_ad_oe = 0;
  logic [7:0] ad_o, hi_o, hi_oe;
  logic ad_oe, ale_o, rd_n_o, wr_n_o, keep_o;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_limit(cfg_limit),
    .cfg_wait_lo(cfg_wait_lo), .cfg_wait_hi(cfg_wait_hi), .cfg_hmask(cfg_hmask),
    .cfg_keep(cfg_keep), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .port_ad_out(port_ad_out),
    .port_ad_oe(port_ad_oe), .port_hi_out(port_hi_out), .port_hi_oe(port_hi_oe),
    .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe), .hi_o(hi_o), .hi_oe(hi_oe),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .keep_o(keep_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic xfer(input bit wr, input logic [15:0] a, input logic [7:0] d,
                      input int exp_s, input bit exp_gap, input string tag);
    int s = 0, extra = 0;
    bit sok = 1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(ale_o == 1 && ad_oe == 1 && ad_o == a[7:0], {tag, " R3 address phase"}, {ale_o, ad_oe, ad_o}, {2'b11, a[7:0]});
    chk(rd_n_o && wr_n_o && !req_ready, {tag, " R13 busy in address phase"}, req_ready, 0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if ((wr ? wr_n_o : rd_n_o) == 1'b0) begin
        if (wr && !(ad_oe && ad_o == d)) sok = 0;
        if (!wr && ad_oe) sok = 0;
        ad_i = d ^ 8'(s);
        s++;
      end else break;
    end
    chk(sok, wr ? {tag, " R7 write data held"} : {tag, " R8 lines float on read"}, sok, 1);
    chk(s == exp_s, {tag, " R4/R6 strobe length"}, s, exp_s);
    chk(ale_o == 0, {tag, " R12 no trailing latch strobe"}, ale_o, 0);
    chk(rsp_valid == !wr, {tag, " R8 response pulse"}, rsp_valid, !wr);
    if (!wr) chk(rsp_rdata == (d ^ 8'(exp_s - 1)), {tag, " R8 last strobe sample"}, rsp_rdata, d ^ 8'(exp_s - 1));
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (req_ready) break;
      extra++;
    end
    chk(extra == int'(exp_gap), {tag, " R5 idle clocks after tail"}, extra, int'(exp_gap));
    chk(rsp_valid == 0, {tag, " R8 single pulse"}, rsp_valid, 0);
  endtask

  task automatic t_reset();
    chk(rd_n_o && wr_n_o && !ale_o && !rsp_valid && req_ready && !ad_oe && !keep_o,
        "R1 reset state", {rd_n_o, wr_n_o, ale_o, rsp_valid, req_ready, ad_oe, keep_o}, 7'b1100100);
  endtask

  task automatic t_no_cycle(input logic [15:0] a, input string tag);
    bit quiet = 1;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 4; k++) begin
      if (ale_o || !rd_n_o || !wr_n_o || rsp_valid || !req_ready) quiet = 0;
      @(negedge clk);
    end
    chk(quiet, {tag, " R2 no external cycle"}, quiet, 1);
  endtask

  task automatic t_sectors();
    cfg_en = 1; cfg_wait_lo = 2'd1; cfg_wait_hi = 2'd2; cfg_limit = 3'd0;
    xfer(1, 16'h1100, 8'h5A, 3, 0, "R6 single sector base");
    xfer(0, 16'h1FFF, 8'h40, 3, 0, "R6 single sector low addr");
    cfg_limit = 3'd1;
    xfer(1, 16'h1FFF, 8'hC3, 2, 0, "R6 limit1 lower");
    xfer(0, 16'h2000, 8'h81, 3, 0, "R6 limit1 upper");
    cfg_limit = 3'd7;
    xfer(0, 16'hDFFF, 8'h11, 2, 0, "R6 limit7 lower");
    xfer(1, 16'hE000, 8'h77, 3, 0, "R6 limit7 upper");
  endtask

  task automatic t_wait_codes();
    cfg_limit = 3'd0;
    cfg_wait_hi = 2'd0; xfer(0, 16'h3456, 8'h20, 1, 0, "R4 code00");
    cfg_wait_hi = 2'd1; xfer(1, 16'h3457, 8'h9E, 2, 0, "R4 code01");
    cfg_wait_hi = 2'd2; xfer(0, 16'h3458, 8'h60, 3, 0, "R4 code10");
    cfg_wait_hi = 2'd3; xfer(1, 16'h3459, 8'hE1, 3, 1, "R5 code11 write");
    xfer(0, 16'h345A, 8'h0F, 3, 1, "R5 code11 read");
  endtask

  task automatic t_back_to_back();
    bit held = 1;
    bit seen = 0;
    cfg_wait_hi = 2'd1;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'h4321; req_wdata = 8'hAB;
    @(negedge clk);
    req_addr = 16'h5678; req_write = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (rd_n_o && wr_n_o) break;
      if (req_ready) held = 0;
    end
    chk(held, "R13 request held off during strobe", held, 1);
    chk(ale_o == 1, "R12 trailing latch strobe with pending request", ale_o, 1);
    @(negedge clk);
    chk(req_ready == 1, "R13 ready returns", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(ale_o && ad_o == 8'h78 && hi_o == 8'h56, "R13 held request address phase", {ad_o, hi_o}, 16'h7856);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (!rd_n_o) seen = 1;
      if (req_ready) break;
    end
    chk(seen && req_ready, "R13 held request completed", {seen, req_ready}, 2'b11);
  endtask

  task automatic t_hmask();
    port_hi_out = 8'hA5; port_hi_oe = 8'h0F; cfg_wait_hi = 2'd0;
    cfg_hmask = 3'd0;
    xfer(1, 16'h1234, 8'h01, 1, 0, "R9 prep");
    chk(hi_o == 8'h12 && hi_oe == 8'hFF, "R9 mask0 all driven", {hi_o, hi_oe}, 16'h12FF);
    cfg_hmask = 3'd3; #1;
    chk(hi_o == 8'hB2 && hi_oe == 8'h1F, "R9 mask3 five driven", {hi_o, hi_oe}, 16'hB21F);
    cfg_hmask = 3'd6; #1;
    chk(hi_o == 8'hA6 && hi_oe == 8'h0F, "R9 mask6 two driven", {hi_o, hi_oe}, 16'hA60F);
    cfg_hmask = 3'd7; #1;
    chk(hi_o == 8'hA5 && hi_oe == 8'h0F, "R9 mask7 none driven", {hi_o, hi_oe}, 16'hA50F);
    cfg_hmask = 3'd0;
  endtask

  task automatic t_disabled();
    @(negedge clk);
    cfg_en = 0; port_hi_out = 8'h3E; port_hi_oe = 8'hC1;
    port_ad_out = 8'h3C; port_ad_oe = 1;
    @(negedge clk);
    chk(hi_o == 8'h3E && hi_oe == 8'hC1 && ad_o == 8'h3C && ad_oe,
        "R10 port values on pins", {hi_o, hi_oe, ad_o}, 24'h3EC13C);
    t_no_cycle(16'h2000, "R10 disabled");
    chk(ad_o == 8'h3C && ad_oe == 1, "R10 disabled request leaves port values", {ad_oe, ad_o}, 9'h13C);
  endtask

  task automatic t_keeper();
    @(negedge clk);
    cfg_keep = 1; port_ad_oe = 0;
    @(negedge clk);
    chk(keep_o && !ad_oe && ad_o == 8'h3C, "R11 keeper holds last byte", {keep_o, ad_o}, 9'h13C);
    cfg_keep = 0;
    @(negedge clk);
    chk(!keep_o && ad_o == 8'h00, "R11 keeper off", {keep_o, ad_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL R13 watchdog expired: actual hang expected completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    cfg_en = 1;
    t_no_cycle(16'h10FF, "R2 internal top");
    t_no_cycle(16'h0000, "R2 internal zero");
    t_sectors();
    t_wait_codes();
    t_back_to_back();
    t_hmask();
    t_disabled();
    t_keeper();
    finish_run();
  end
endmodule